// File: doc/BRIEF.md
# Walking-Ones Data Bus Tester

This block is a built-in test engine for the data lines between a master and a synchronous single-port memory. A start pulse makes it capture a target address. It then writes a word with a single 1 bit to that address, reads the word back and compares it with what it wrote. After each matching step the set bit moves one place towards the most significant end, until every data line has carried the lone 1.

The engine stops at the first word that does not read back correctly. It then pulses done, raises a fail flag and returns the exact pattern that failed. When every pattern matches, the result is zero and the fail flag is low. Both stay stable until the next start, so a bring-up sequencer can read them at leisure. The memory's read latency is a parameter, so the same engine fits memories with different pipeline depths.

Top module: `wob_tester`

## Requirements
- R1: After reset, done, fail, memWe and memRe are low and result is zero.
- R2: A start in idle begins a run. Its first written word is 1 (bit 0 set), and each later write shifts the set bit up by one place. A full run has exactly DATA_W writes, each with exactly one bit set.
- R3: Every write and read of a run uses the address that was on testAddr in the cycle start was accepted.
- R4: Each step is a one-cycle write strobe, then a one-cycle read strobe in the next cycle. The read data is compared RD_LAT cycles after the read strobe cycle, and memWe and memRe are never high together.
- R5: If every pattern reads back equal, done pulses with fail low and result zero.
- R6: At the first mismatch the run ends with no further memory strobe. Done pulses with fail high, and result equals the pattern that was written in the failing step.
- R7: Done is high for exactly one cycle, and fail and result keep their values until the next accepted start.
- R8: A start that arrives while a run is in progress has no effect: the address and the pattern sequence are unchanged, and only one done is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only in idle) |
| testAddr | input | ADDR_W | Address to test, captured at start |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | High when the last run found a mismatch |
| result | output | DATA_W | First failing pattern, zero on pass |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid RD_LAT cycles after memRe |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |

## Verification
The bench builds the block with an 8-bit data bus, a 6-bit address and a read latency of 3 cycles. With a three-cycle latency, the wait counter passes through intermediate values. The bench memory model returns zero on read cycles that carry no valid data, so a comparison taken one cycle too early or too late shows up as a mismatch. Faults injected on the memory side (stuck-at-0, stuck-at-1 on the lowest bit, bridged lines, an absent device) drive the engine to stop at the first pattern, at a middle pattern and at the last pattern.

// File: rtl/wob_pkg.sv
package wob_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_WAIT  = 2'd3
  } wobState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic initPat;
    logic shiftPat;
    logic clrRes;
    logic capFail;
    logic capPass;
    logic drvWrite;
  } wobCtrl_t;

endpackage

// File: rtl/wob_datapath.sv
module wob_datapath
  import wob_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  wobCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] testAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              mismatch,
  output logic              lastBit,
  output logic              fail,
  output logic [DATA_W-1:0] result
);

  localparam logic [DATA_W-1:0] FIRST_PAT = DATA_W'(1);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] patQ;
  logic [DATA_W-1:0] resultQ;
  logic              failQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (ctrl.loadAddr) begin
      addrQ <= testAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patQ <= FIRST_PAT;
    end else if (ctrl.initPat) begin
      patQ <= FIRST_PAT;
    end else if (ctrl.shiftPat) begin
      patQ <= {patQ[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      failQ   <= 1'b0;
    end else if (ctrl.clrRes || ctrl.capPass) begin
      resultQ <= '0;
      failQ   <= 1'b0;
    end else if (ctrl.capFail) begin
      resultQ <= patQ;
      failQ   <= 1'b1;
    end
  end

  assign memAddr  = addrQ;
  assign memWdata = ctrl.drvWrite ? patQ : '0;
  assign mismatch = (memRdata != patQ);
  assign lastBit  = patQ[DATA_W-1];
  assign fail     = failQ;
  assign result   = resultQ;

  // R2
  onehot_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.drvWrite |-> ($countones(memWdata) == 1));

  // R6
  fail_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capFail |=> (fail && (result == $past(patQ))));

  // R5
  pass_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capPass |=> (!fail && (result == '0)));

endmodule

// File: rtl/wob_control.sv
module wob_control
  import wob_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     mismatch,
  input  logic     lastBit,
  output wobCtrl_t ctrl,
  output logic     memWe,
  output logic     memRe,
  output logic     done
);

  localparam int CNT_W = (RD_LAT < 2) ? 1 : $clog2(RD_LAT);
  localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(RD_LAT - 1);

  wobState_t stateQ, stateD;
  logic [CNT_W-1:0] latCntQ, latCntD;
  logic doneQ, doneD;
  logic latReached;

  assign latReached = (latCntQ == LAT_LAST);

  always_comb begin
    stateD  = stateQ;
    latCntD = latCntQ;
    doneD   = 1'b0;
    ctrl    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.loadAddr = 1'b1;
          ctrl.initPat  = 1'b1;
          ctrl.clrRes   = 1'b1;
          stateD        = ST_WRITE;
        end
      end
      ST_WRITE: begin
        ctrl.drvWrite = 1'b1;
        stateD        = ST_READ;
      end
      ST_READ: begin
        latCntD = '0;
        stateD  = ST_WAIT;
      end
      ST_WAIT: begin
        if (latReached) begin
          if (mismatch) begin
            ctrl.capFail = 1'b1;
            doneD        = 1'b1;
            stateD       = ST_IDLE;
          end else if (lastBit) begin
            ctrl.capPass = 1'b1;
            doneD        = 1'b1;
            stateD       = ST_IDLE;
          end else begin
            ctrl.shiftPat = 1'b1;
            stateD        = ST_WRITE;
          end
        end else begin
          latCntD = latCntQ + 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      latCntQ <= '0;
      doneQ   <= 1'b0;
    end else begin
      stateQ  <= stateD;
      latCntQ <= latCntD;
      doneQ   <= doneD;
    end
  end

  assign memWe = (stateQ == ST_WRITE);
  assign memRe = (stateQ == ST_READ);
  assign done  = doneQ;

  // R4
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R4
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> $past(memWe));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memWe && !memRe));

  // R8
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && (stateQ != ST_IDLE)) |-> !ctrl.loadAddr);

endmodule

// File: rtl/wob_tester.sv
module wob_tester
  import wob_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] testAddr,
  output logic              done,
  output logic              fail,
  output logic [DATA_W-1:0] result,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  output logic              memRe
);

  wobCtrl_t ctrl;
  logic     mismatch;
  logic     lastBit;

  wob_control #(
    .RD_LAT(RD_LAT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mismatch(mismatch),
    .lastBit (lastBit),
    .ctrl    (ctrl),
    .memWe   (memWe),
    .memRe   (memRe),
    .done    (done)
  );

  wob_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .testAddr(testAddr),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .mismatch(mismatch),
    .lastBit (lastBit),
    .fail    (fail),
    .result  (result)
  );

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clrRes && !ctrl.capFail && !ctrl.capPass) |=> ($stable(result) && $stable(fail)));

endmodule

// File: tb/tb_wob_tester.sv
module tb_wob_tester;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int RD_LAT = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct {
    logic             fail;
    logic [DATA_W-1:0] res;
    int               writes;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] testAddr = '0;
  logic              done;
  logic              fail;
  logic [DATA_W-1:0] result;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata;
  logic              memWe;
  logic              memRe;

  int nChecks = 0;
  int nFails  = 0;
  int doneCnt = 0;
  int wrIdx   = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  logic prevDone = 1'b0;
  logic prevWe   = 1'b0;
  expItem_t expQ[$];

  // fault model: 0 none, 1 stuck-at-0 on fa, 2 stuck-at-1 on fa, 3 fa/fb AND-bridged
  int   fKind = 0;
  int   fa = 0;
  int   fb = 0;
  logic missing = 1'b0;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] pipe [RD_LAT];

  always #4 clk = ~clk;

  wob_tester #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .RD_LAT(RD_LAT)
  ) dut (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .testAddr(testAddr),
    .done    (done),
    .fail    (fail),
    .result  (result),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memRdata(memRdata),
    .memWe   (memWe),
    .memRe   (memRe)
  );

  function automatic logic [DATA_W-1:0] faultFn(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    logic b;
    r = d;
    case (fKind)
      1: r[fa] = 1'b0;
      2: r[fa] = 1'b1;
      3: begin
        b = d[fa] & d[fb];
        r[fa] = b;
        r[fb] = b;
      end
      default: ;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (memWe && !missing) mem[memAddr] <= faultFn(memWdata);
    pipe[0] <= (memRe && !missing) ? mem[memAddr] : '0;
    for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign memRdata = pipe[RD_LAT-1];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        check(memAddr == expAddr, "R3 write address", 32'(memAddr), 32'(expAddr));
        check(memWdata == DATA_W'(1) << wrIdx, "R2 pattern", 32'(memWdata), 32'(DATA_W'(1) << wrIdx));
        wrIdx++;
      end
      if (memRe) begin
        check(memAddr == expAddr, "R3 read address", 32'(memAddr), 32'(expAddr));
        check(prevWe, "R4 read follows write", 32'(prevWe), 32'd1);
      end
      if (done) begin
        check(!prevDone, "R7 done pulse", 32'(prevDone), 32'd0);
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(fail == e.fail, "R5/R6 fail flag", 32'(fail), 32'(e.fail));
          check(result == e.res, "R5/R6 result", 32'(result), 32'(e.res));
          check(wrIdx == e.writes, "R6 writes before stop", 32'(wrIdx), 32'(e.writes));
        end
        wrIdx = 0;
        doneCnt++;
      end
      prevDone = done;
      prevWe   = memWe;
    end
  end

  task automatic runTest(input logic [ADDR_W-1:0] addr, input int kind, input int a, input int b,
                         input logic miss, input bit interfere);
    expItem_t e;
    int target;
    logic [DATA_W-1:0] p;
    logic [DATA_W-1:0] got;
    fKind = kind; fa = a; fb = b; missing = miss;
    e.fail = 1'b0; e.res = '0; e.writes = DATA_W;
    for (int i = 0; i < DATA_W; i++) begin
      p = DATA_W'(1) << i;
      got = miss ? '0 : faultFn(p);
      if (got != p) begin
        e.fail = 1'b1; e.res = p; e.writes = i + 1;
        break;
      end
    end
    expAddr = addr;
    expQ.push_back(e);
    target = doneCnt + 1;
    @(negedge clk);
    testAddr = addr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    testAddr = ~addr;
    if (interfere) begin
      // R8: start during a run
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCnt < target) @(negedge clk);
    repeat (6) @(negedge clk);
    // R7: outputs held; R6: no more strobes
    check(fail == e.fail, "R7 fail held", 32'(fail), 32'(e.fail));
    check(result == e.res, "R7 result held", 32'(result), 32'(e.res));
    check(!memWe && !memRe, "R6 idle strobes", 32'({memWe, memRe}), 32'd0);
    check(doneCnt == target, "R8 single done", 32'(doneCnt), 32'(target));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    for (int i = 0; i < RD_LAT; i++) pipe[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check(!done && !fail && result == '0 && !memWe && !memRe, "R1 reset state",
          32'({done, fail, memWe, memRe, result}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !memWe && !memRe, "R1 idle after reset", 32'({done, memWe, memRe}), 32'd0);

    runTest(6'h15, 0, 0, 0, 1'b0, 1'b0);   // R5 clean pass
    runTest(6'h2A, 1, 3, 0, 1'b0, 1'b0);   // R6 stuck-at-0 middle bit
    runTest(6'h01, 1, 7, 0, 1'b0, 1'b0);   // R6 fails on last pattern
    runTest(6'h3F, 2, 0, 0, 1'b0, 1'b0);   // R6 stuck-at-1 bit 0 -> second pattern
    runTest(6'h00, 3, 5, 2, 1'b0, 1'b0);   // R6 bridged lines
    runTest(6'h07, 0, 0, 0, 1'b1, 1'b0);   // R6 absent device, first pattern
    runTest(6'h33, 0, 0, 0, 1'b0, 1'b1);   // R8 start while busy, pass
    runTest(6'h0C, 1, 6, 0, 1'b0, 1'b1);   // R8 start while busy, fail
    runTest(6'h20, 0, 0, 0, 1'b0, 1'b0);   // R7 clears old fail on new start

    check(expQ.size() == 0, "R8 pending items", 32'(expQ.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule